// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs a sixteen-state controller that steps on each rising edge of the test clock under the mode-select input. It holds a three-bit instruction, and it routes one of three data registers between the serial input and the serial output. The three data registers are a one-bit bypass stage, a 32-bit identification word and a boundary register of `NPIN + NSPARE` cells. The boundary register samples the chip's pins. On command it also takes over the pin outputs, or it forces every pin driver to high impedance.

The block has no reset pin. It powers up in Test-Logic-Reset with the identification instruction active. Five consecutive rising edges with mode-select high return it to that state from any state. The serial output changes only on falling clock edges. A separate enable marks when the serial output would be driven: it is high only in the two shift states.

Top module: `scan_tap`

## Requirements
- R1: At power-up, and after five consecutive rising edges of `tck` with `tms` high from any controller state, the controller is in Test-Logic-Reset and the active instruction is the identification code 001.
- R2: With instruction 001 active, Capture-DR loads the 32-bit word `ID_CODE` with bit 0 forced to 1. The word shifts out least significant bit first.
- R3: Capture-IR loads the instruction shift stage with 001 (bits [1:0] = 01, bit 2 = 0). The stage shifts out least significant bit first.
- R4: A shifted instruction becomes active on the rising edge that enters Update-IR, and not before. Until then, for example while in Pause-IR, the previous instruction keeps control of the pins.
- R5: Instruction 111, and the unassigned codes 011, 101 and 110, select the one-bit bypass stage. This stage captures 0, so the serial output is a 0 followed by the serial input delayed by one shift. The pins keep their functional values.
- R6: Instruction 100 (sample/preload) makes the boundary register capture `pinIn` into cells 0..NPIN-1 and a constant 1 into cells NPIN..NPIN+NSPARE-1. The pins keep their functional values (`pinOut` = `coreOut`, `pinOe` = `coreOe`).
- R7: Instruction 000 (external test) drives `pinOut` from the boundary update latch with every `pinOe` bit at 1. The latch takes the low NPIN boundary cells on the rising edge that enters Update-DR, and holds them otherwise.
- R8: Instruction 010 (sample with pins off) forces every `pinOe` bit to 0 while the boundary register still captures the pins as in R6.
- R9: `tdoEn` is 1 exactly while the controller is in Shift-IR or Shift-DR. `tdo` and `tdoEn` change only on falling edges of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial data in, sampled on rising edges |
| pinIn | input | NPIN | Pin levels seen by the capture cells |
| coreOut | input | NPIN | Functional output values from the core |
| coreOe | input | NPIN | Functional output enables from the core |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdoEn | output | 1 | High when tdo should be driven |
| pinOut | output | NPIN | Output values delivered to the pads |
| pinOe | output | NPIN | Output enables delivered to the pads |

## Verification
The bench builds the block with NPIN = 5 and NSPARE = 3, so the boundary register has 8 cells. Three of those cells are constant ones that sit above the pin cells. This makes the spare-cell capture and the split between pin cells and spare cells visible in every boundary shift. The identification parameter is given an even value, so the forced bit 0 is checked. With only five pins, the forced-reset sweep can visit each of the sixteen controller states and still finish in a short run.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} drSel_e;

  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   updateDr;
    logic   updateIr;
    logic   enterReset;
    drSel_e drSel;
    logic   inShiftIr;
    logic   inShiftDr;
    logic   irBit;
    logic   extestOn;
    logic   pinsOff;
  } tapStrobe_t;
endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output tapStrobe_t      strb,
  output tapState_e       curState,
  output logic [IR_W-1:0] activeIr
);
  tapState_e       state = ST_RESET;
  tapState_e       nxt;
  logic [IR_W-1:0] irSh = '0;
  logic [IR_W-1:0] irAct = OP_IDENT;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
    endcase
  end

  always_ff @(posedge tck) begin
    state <= nxt;
    if (state == ST_CAP_IR)
      irSh <= IR_W'(1);
    else if (state == ST_SH_IR)
      irSh <= {tdi, irSh[IR_W-1:1]};
    if (nxt == ST_RESET)
      irAct <= OP_IDENT;
    else if (nxt == ST_UPD_IR)
      irAct <= irSh;
  end

  always_comb begin
    strb            = '0;
    strb.captureDr  = (state == ST_CAP_DR);
    strb.shiftDr    = (state == ST_SH_DR);
    strb.updateDr   = (nxt == ST_UPD_DR);
    strb.updateIr   = (nxt == ST_UPD_IR);
    strb.enterReset = (nxt == ST_RESET);
    strb.inShiftIr  = (state == ST_SH_IR);
    strb.inShiftDr  = (state == ST_SH_DR);
    strb.irBit      = irSh[0];
    strb.extestOn   = (irAct == OP_EXTEST);
    strb.pinsOff    = (irAct == OP_SAMPZ);
    case (irAct)
      OP_IDENT:                       strb.drSel = SEL_ID;
      OP_EXTEST, OP_SAMPLE, OP_SAMPZ: strb.drSel = SEL_BSR;
      default:                        strb.drSel = SEL_BYP;
    endcase
  end

  assign curState = state;
  assign activeIr = irAct;
endmodule

// File: rtl/scan_tap_data.sv
module scan_tap_data
  import scan_tap_pkg::*;
#(
  parameter int              NPIN    = 8,
  parameter int              NSPARE  = 2,
  parameter logic [ID_W-1:0] ID_CODE = 32'h4D2A_91C7
) (
  input  logic            tck,
  input  logic            tdi,
  input  tapStrobe_t      strb,
  input  logic [NPIN-1:0] pinIn,
  output logic            tdo,
  output logic            tdoEn,
  output logic [NPIN-1:0] bsrLatch
);
  localparam int BSR_LEN = NPIN + NSPARE;

  logic               bypReg = 1'b0;
  logic [ID_W-1:0]    idReg  = '0;
  logic [BSR_LEN-1:0] bsrReg = '0;
  logic [BSR_LEN-1:0] capVec;
  logic [NPIN-1:0]    updReg = '0;
  logic               drLsb;
  logic               tdoReg = 1'b0;
  logic               enReg  = 1'b0;

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i < NPIN) begin : g_pin
      assign capVec[i] = pinIn[i];
    end else begin : g_spare
      assign capVec[i] = 1'b1;
    end
  end

  always_ff @(posedge tck) begin
    unique case (strb.drSel)
      SEL_ID: begin
        if (strb.captureDr)    idReg <= {ID_CODE[ID_W-1:1], 1'b1};
        else if (strb.shiftDr) idReg <= {tdi, idReg[ID_W-1:1]};
      end
      SEL_BSR: begin
        if (strb.captureDr)    bsrReg <= capVec;
        else if (strb.shiftDr) bsrReg <= {tdi, bsrReg[BSR_LEN-1:1]};
        if (strb.updateDr)     updReg <= bsrReg[NPIN-1:0];
      end
      default: begin
        if (strb.captureDr)    bypReg <= 1'b0;
        else if (strb.shiftDr) bypReg <= tdi;
      end
    endcase
  end

  always_comb begin
    unique case (strb.drSel)
      SEL_ID:  drLsb = idReg[0];
      SEL_BSR: drLsb = bsrReg[0];
      default: drLsb = bypReg;
    endcase
  end

  always_ff @(negedge tck) begin
    enReg  <= strb.inShiftIr | strb.inShiftDr;
    tdoReg <= strb.inShiftIr ? strb.irBit : drLsb;
  end

  assign tdo      = tdoReg;
  assign tdoEn    = enReg;
  assign bsrLatch = updReg;
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              NPIN    = 8,
  parameter int              NSPARE  = 2,
  parameter logic [ID_W-1:0] ID_CODE = 32'h4D2A_91C7
) (
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  input  logic [NPIN-1:0] pinIn,
  input  logic [NPIN-1:0] coreOut,
  input  logic [NPIN-1:0] coreOe,
  output logic            tdo,
  output logic            tdoEn,
  output logic [NPIN-1:0] pinOut,
  output logic [NPIN-1:0] pinOe
);
  tapStrobe_t      strb;
  tapState_e       curState;
  logic [IR_W-1:0] activeIr;
  logic [NPIN-1:0] bsrLatch;

  scan_tap_ctrl uCtrl (
    .tck(tck), .tms(tms), .tdi(tdi),
    .strb(strb), .curState(curState), .activeIr(activeIr)
  );

  scan_tap_data #(.NPIN(NPIN), .NSPARE(NSPARE), .ID_CODE(ID_CODE)) uData (
    .tck(tck), .tdi(tdi), .strb(strb), .pinIn(pinIn),
    .tdo(tdo), .tdoEn(tdoEn), .bsrLatch(bsrLatch)
  );

  assign pinOut = strb.extestOn ? bsrLatch : coreOut;
  assign pinOe  = strb.extestOn ? '1 : (strb.pinsOff ? '0 : coreOe);
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic            tck,
  input logic            tms,
  input logic            tdoEn,
  input logic [NPIN-1:0] pinOut,
  input logic [NPIN-1:0] pinOe,
  input tapStrobe_t      strb,
  input tapState_e       curState,
  input logic [IR_W-1:0] activeIr
);
  logic       warm = 1'b0;
  logic [2:0] ones = '0;

  always_ff @(posedge tck) begin
    warm <= 1'b1;
    ones <= tms ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
  end

  a_r1_five_ones: assert property (@(posedge tck) disable iff (!warm)
    (tms && ones >= 3'd4) |=> (curState == ST_RESET));

  a_r4_instr_hold: assert property (@(posedge tck) disable iff (!warm)
    !(strb.updateIr || strb.enterReset) |=> $stable(activeIr));

  a_r7_latch_hold: assert property (@(posedge tck) disable iff (!warm)
    (strb.extestOn && !strb.updateDr && !strb.updateIr && !strb.enterReset)
      |=> $stable(pinOut));

  a_r8_pins_off: assert property (@(posedge tck) disable iff (!warm)
    (activeIr == OP_SAMPZ) |-> (pinOe == '0));

  a_r9_tdo_enable: assert property (@(posedge tck) disable iff (!warm)
    tdoEn == (curState == ST_SH_DR || curState == ST_SH_IR));
endmodule

bind scan_tap scan_tap_chk #(.NPIN(NPIN)) uChk (
  .tck(tck), .tms(tms), .tdoEn(tdoEn), .pinOut(pinOut), .pinOe(pinOe),
  .strb(strb), .curState(curState), .activeIr(activeIr)
);

// File: tb/sim_scan_tap.sv
module sim_scan_tap;
  localparam int          CLK_PERIOD = 20;
  localparam int          NPIN       = 5;
  localparam int          NSPARE     = 3;
  localparam int          BLEN       = NPIN + NSPARE;
  localparam logic [31:0] ID_PARAM   = 32'h4D2A_91C6;
  localparam logic [31:0] ID_EXP     = 32'h4D2A_91C7;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NPIN-1:0] pinIn, coreOut, coreOe;
  logic tdo, tdoEn;
  logic [NPIN-1:0] pinOut, pinOe;

  int nChecks = 0, nFails = 0;
  int mState = 0;
  logic prevTdo = 1'b0;

  scan_tap #(.NPIN(NPIN), .NSPARE(NSPARE), .ID_CODE(ID_PARAM)) u0 (
    .tck(tck), .tms(tms), .tdi(tdi), .pinIn(pinIn), .coreOut(coreOut), .coreOe(coreOe),
    .tdo(tdo), .tdoEn(tdoEn), .pinOut(pinOut), .pinOe(pinOe)
  );

  function automatic int nextSt(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (ok !== 1'b1) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic q);
    tms = m; tdi = d;
    #(CLK_PERIOD/4) tck = 1'b1;
    mState = nextSt(mState, m);
    #(CLK_PERIOD/4);
    check(tdo === prevTdo, "R9 tdo held after rising edge", 64'(tdo), 64'(prevTdo));
    #(CLK_PERIOD/4) tck = 1'b0;
    #(CLK_PERIOD/4);
    q = tdo; prevTdo = tdo;
    check(tdoEn === ((mState == 4 || mState == 11) ? 1'b1 : 1'b0), "R9 tdoEn vs state",
          64'(tdoEn), 64'(mState));
  endtask

  // From Run-Test/Idle to Exit1-IR, returning the captured instruction stage
  task automatic irShift(input logic [2:0] op, output logic [2:0] cap);
    logic q;
    step(1, 0, q); step(1, 0, q); step(0, 0, q); step(0, 0, q);
    cap[0] = q;
    for (int k = 0; k < 3; k++) begin
      step(k == 2, op[k], q);
      if (k < 2) cap[k+1] = q;
    end
  endtask

  // From Run-Test/Idle to Exit1-DR
  task automatic drShift(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic q;
    dout = '0;
    step(1, 0, q); step(0, 0, q); step(0, 0, q);
    dout[0] = q;
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], q);
      if (k < n - 1) dout[k+1] = q;
    end
  endtask

  task automatic finishScan();
    logic q;
    step(1, 0, q); step(0, 0, q);
  endtask

  task automatic loadIr(input logic [2:0] op);
    logic [2:0] c;
    irShift(op, c);
    finishScan();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired (R1..R9 incomplete) actual=hung expected=done");
    summary();
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] dout;
    logic [7:0]  pre, nxt8;
    logic        q;
    pinIn = 5'b10110; coreOut = 5'b01001; coreOe = 5'b00101;
    #1;
    check(tdoEn === 1'b0, "R9 reset tdoEn", 64'(tdoEn), 0);
    check(pinOe === coreOe, "R6 reset pinOe functional", 64'(pinOe), 64'(coreOe));
    check(pinOut === coreOut, "R6 reset pinOut functional", 64'(pinOut), 64'(coreOut));

    // R1/R2: power-up state carries the identification instruction
    step(0, 0, q);
    drShift(32, 64'h0, dout); finishScan();
    check(dout[31:0] === ID_EXP, "R1 R2 power-up id shift", dout, 64'(ID_EXP));

    // R3: instruction capture pattern; R5: bypass latency
    irShift(3'b111, cap); finishScan();
    check(cap === 3'b001, "R3 capture-IR pattern", 64'(cap), 64'h1);
    drShift(8, 64'h5B, dout); finishScan();
    check(dout[7:0] === 8'hB6, "R5 bypass delay", dout, 64'hB6);

    // R5: unassigned codes behave as bypass
    foreach (cap[i]) ; // no-op to keep cap used
    for (int c = 0; c < 3; c++) begin
      logic [2:0] op;
      op = (c == 0) ? 3'b011 : (c == 1) ? 3'b101 : 3'b110;
      loadIr(op);
      drShift(8, 64'hC3, dout); finishScan();
      check(dout[7:0] === 8'h86, "R5 reserved code bypass", dout, 64'h86);
      check(pinOe === coreOe && pinOut === coreOut, "R5 reserved pins functional",
            64'({pinOut, pinOe}), 64'({coreOut, coreOe}));
    end

    // R6: sample/preload captures pins and spare ones
    loadIr(3'b100);
    check(pinOe === coreOe && pinOut === coreOut, "R6 sample pins functional",
          64'({pinOut, pinOe}), 64'({coreOut, coreOe}));
    pre = 8'b000_11010;
    drShift(BLEN, 64'(pre), dout); finishScan();
    check(dout[7:0] === {3'b111, pinIn}, "R6 boundary capture", dout, 64'({3'b111, pinIn}));

    // R4: extest shifted in but not active before Update-IR
    irShift(3'b000, cap);
    step(0, 0, q);
    check(pinOe === coreOe, "R4 previous instruction holds in pause", 64'(pinOe), 64'(coreOe));
    step(1, 0, q);
    finishScan();
    check(pinOut === pre[4:0], "R7 extest drives latch", 64'(pinOut), 64'(pre[4:0]));
    check(pinOe === 5'b11111, "R7 extest enables all", 64'(pinOe), 64'h1F);

    // R7: latch holds until Update-DR
    pinIn = 5'b01101;
    nxt8 = 8'b101_00111;
    drShift(BLEN, 64'(nxt8), dout);
    check(dout[7:0] === {3'b111, pinIn}, "R7 extest capture", dout, 64'({3'b111, pinIn}));
    step(0, 0, q);
    check(pinOut === pre[4:0], "R7 latch held in pause", 64'(pinOut), 64'(pre[4:0]));
    step(1, 0, q);
    finishScan();
    check(pinOut === nxt8[4:0], "R7 latch after update", 64'(pinOut), 64'(nxt8[4:0]));

    // R8: sample with pins off
    loadIr(3'b010);
    check(pinOe === 5'b00000, "R8 all enables off", 64'(pinOe), 0);
    pinIn = 5'b11001;
    drShift(BLEN, 64'h0, dout); finishScan();
    check(dout[7:0] === {3'b111, pinIn}, "R8 capture with pins off", dout,
          64'({3'b111, pinIn}));

    // R2: identification through explicit instruction load
    loadIr(3'b001);
    check(pinOe === coreOe, "R6 id instruction pins functional", 64'(pinOe), 64'(coreOe));
    drShift(32, 64'h0, dout); finishScan();
    check(dout[31:0] === ID_EXP, "R2 id shift", dout, 64'(ID_EXP));

    // R1: five ones return to reset from every state
    for (int s = 0; s < 16; s++) begin
      logic [5:0] path;
      int len;
      case (s)
        0: begin path = 6'b000111; len = 3; end
        1: begin path = 6'b000000; len = 0; end
        2: begin path = 6'b000001; len = 1; end
        3: begin path = 6'b000001; len = 2; end
        4: begin path = 6'b000001; len = 3; end
        5: begin path = 6'b000101; len = 3; end
        6: begin path = 6'b000101; len = 4; end
        7: begin path = 6'b010101; len = 5; end
        8: begin path = 6'b001101; len = 4; end
        9: begin path = 6'b000011; len = 2; end
        10: begin path = 6'b000011; len = 3; end
        11: begin path = 6'b000011; len = 4; end
        12: begin path = 6'b001011; len = 4; end
        13: begin path = 6'b001011; len = 5; end
        14: begin path = 6'b101011; len = 6; end
        default: begin path = 6'b011011; len = 5; end
      endcase
      loadIr(3'b111);
      for (int k = 0; k < len; k++) step(path[k], 1'b1, q);
      repeat (5) step(1, 0, q);
      step(0, 0, q);
      drShift(32, 64'h0, dout); finishScan();
      check(dout[31:0] === ID_EXP, $sformatf("R1 five-ones reset from state %0d", s),
            dout, 64'(ID_EXP));
    end

    summary();
  end
endmodule